// File: doc/BRIEF.md
# Activity-Reloaded Inactivity Timer

This block is the idle watchdog for a power-management controller. A down-counter runs from a programmable start value, one step per tick pulse. When the counter reaches zero the block raises a one-cycle expiry strobe, which tells the power controller that the system has been idle long enough to lower its power state. Any enabled sign of system activity sends the counter back to its start value. The counter then stays at zero until the next such reload.

Activity arrives on four kinds of input. Thirteen per-source access-trap strobes come from peripheral decoders. An external SMI status level comes from outside. A bus-master request is a third kind. Sixteen interrupt lines are the fourth. Line 2 of these carries the legacy interrupt controller's INTR output, not IRQ2. Two mask registers choose which sources may reload the counter. Software reaches them, and the start value, over a simple synchronous write port with a combinational read port.

Top module: `idle_timer_top`

## Requirements
- R1: Register map by `reg_addr`: 0 is the source mask, 1 is the interrupt mask, 2 is the start value (low 16 bits), and 3 is the current count (read-only, low 16 bits). After reset, the source and interrupt masks read 0 and the start value and count read 0xFFFF.
- R2: Writable bits are 21:7 of the source mask, 15:0 of the interrupt mask, and 15:0 of the start value. Every other bit reads 0, and writes to it have no effect. Writing all ones reads back 0x003FFF80 at address 0 and 0x0000FFFF at address 1.
- R3: Trap strobe `trap_stb[i]` (i = 0..12) is enabled by source-mask bit 7+i. The order is: serial port B, audio, video, keyboard/mouse, card slot 1, card slot 2, USB, I/O range monitors 1 to 4, and memory range monitors 1 and 2. An enabled strobe loads the start value into the counter at the clock edge where the strobe is sampled high.
- R4: A trap strobe whose mask bit is 0 leaves the count unchanged.
- R5: While source-mask bit 20 is 1 and `smi_status` is high, the count is reloaded on every edge, so ticks do not decrement it. Once the level drops, counting resumes.
- R6: With source-mask bit 21 set, a rising edge of `bm_req` reloads the counter at the edge where the request is first sampled high. A request held high does not reload it again.
- R7: Interrupt-mask bit n enables `irq_lines[n]`, where bit 2 is the legacy controller's INTR output. Both a rising and a falling transition of an enabled line reload the counter. The reload is visible after the third rising clock edge following the change, because of a two-stage synchronizer and an edge register.
- R8: A transition on a line whose interrupt-mask bit is 0 leaves the count unchanged.
- R9: A `tick` sampled high with no reload pending lowers a nonzero count by one. If a reload and a tick come in the same cycle, the reload wins.
- R10: On the edge where a tick takes the count from 1 to 0, `expired` rises for exactly one cycle. After that the count stays at 0, and further ticks give no new expiry until a reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (combinational on reg_addr) |
| trap_stb | input | 13 | Per-source access-trap strobes |
| smi_status | input | 1 | External SMI status level |
| bm_req | input | 1 | Bus-master request |
| irq_lines | input | 16 | Interrupt lines; bit 2 is INTR |
| tick | input | 1 | Count-down enable pulse |
| expired | output | 1 | One-cycle strobe when the count reaches zero |

## Verification
Trap, SMI and bus-master reloads, and tick decrements, show on the count at the first rising edge that samples the stimulus. The expiry strobe is high in the cycle that follows that same edge. Interrupt transitions reach the count only after the third edge. The bench drives every input on a falling edge and reads on a later falling edge. For interrupt reloads it checks after the second edge that the count has not yet changed, and after the third edge that it has been reloaded, so that an extra or missing stage shows up as a failure.

// File: rtl/idle_pkg.sv
package idle_pkg;
    localparam int DATA_W   = 32;
    localparam int CNT_W    = 16;
    localparam int N_TRAP   = 13;
    localparam int N_IRQ    = 16;
    localparam int TRAP_LO  = 7;
    localparam int SMI_BIT  = TRAP_LO + N_TRAP;
    localparam int BM_BIT   = SMI_BIT + 1;
    localparam logic [CNT_W-1:0] START_RST = '1;

    typedef enum logic [1:0] {
        ADDR_SRC   = 2'd0,
        ADDR_IRQ   = 2'd1,
        ADDR_START = 2'd2,
        ADDR_COUNT = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [N_TRAP-1:0] trap_en;
        logic              smi_en;
        logic              bm_en;
        logic [N_IRQ-1:0]  irq_en;
        logic [CNT_W-1:0]  start_val;
    } idle_cfg_t;

    function automatic logic [DATA_W-1:0] src_writable();
        logic [DATA_W-1:0] m;
        m = '0;
        for (int i = TRAP_LO; i <= BM_BIT; i++) m[i] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/idle_regs.sv
module idle_regs
    import idle_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CNT_W-1:0]  count,
    output logic [DATA_W-1:0] rdata,
    output idle_cfg_t         cfg
);
    localparam logic [DATA_W-1:0] SRC_WMASK = src_writable();

    logic [DATA_W-1:0] src_q;
    logic [N_IRQ-1:0]  irq_q;
    logic [CNT_W-1:0]  start_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q   <= '0;
            irq_q   <= '0;
            start_q <= START_RST;
        end else if (we) begin
            unique case (reg_sel_e'(addr))
                ADDR_SRC:   src_q   <= wdata & SRC_WMASK;
                ADDR_IRQ:   irq_q   <= wdata[N_IRQ-1:0];
                ADDR_START: start_q <= wdata[CNT_W-1:0];
                default:    ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        unique case (reg_sel_e'(addr))
            ADDR_SRC:   rdata = src_q;
            ADDR_IRQ:   rdata[N_IRQ-1:0] = irq_q;
            ADDR_START: rdata[CNT_W-1:0] = start_q;
            default:    rdata[CNT_W-1:0] = count;
        endcase
    end

    assign cfg.trap_en   = src_q[TRAP_LO +: N_TRAP];
    assign cfg.smi_en    = src_q[SMI_BIT];
    assign cfg.bm_en     = src_q[BM_BIT];
    assign cfg.irq_en    = irq_q;
    assign cfg.start_val = start_q;

    assert_src_reserved_R2: assert property (@(posedge clk) disable iff (rst)
        (addr == ADDR_SRC) |-> ((rdata & ~SRC_WMASK) == '0));
    assert_irq_reserved_R2: assert property (@(posedge clk) disable iff (rst)
        (addr == ADDR_IRQ) |-> (rdata[DATA_W-1:N_IRQ] == '0));
endmodule

// File: rtl/idle_activity.sv
module idle_activity
    import idle_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  idle_cfg_t         cfg,
    input  logic [N_TRAP-1:0] trap_stb,
    input  logic              smi_status,
    input  logic              bm_req,
    input  logic [N_IRQ-1:0]  irq_lines,
    output logic              reload
);
    logic [N_IRQ-1:0] sync1_q, sync2_q, prev_q;
    logic             bm_prev_q;
    logic [N_IRQ-1:0] irq_hit;
    logic             trap_hit, smi_hit, bm_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1_q   <= '0;
            sync2_q   <= '0;
            prev_q    <= '0;
            bm_prev_q <= 1'b0;
        end else begin
            sync1_q   <= irq_lines;
            sync2_q   <= sync1_q;
            prev_q    <= sync2_q;
            bm_prev_q <= bm_req;
        end
    end

    generate
        for (genvar n = 0; n < N_IRQ; n++) begin : g_irq
            assign irq_hit[n] = cfg.irq_en[n] & (sync2_q[n] ^ prev_q[n]);
        end
    endgenerate

    assign trap_hit = |(trap_stb & cfg.trap_en);
    assign smi_hit  = cfg.smi_en & smi_status;
    assign bm_hit   = cfg.bm_en & bm_req & ~bm_prev_q;
    assign reload   = trap_hit | smi_hit | bm_hit | (|irq_hit);

    assert_masked_trap_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        (cfg.trap_en == '0 && !smi_hit && !bm_hit && irq_hit == '0) |-> !reload);
    assert_bm_single_R6: assert property (@(posedge clk) disable iff (rst)
        bm_hit |=> !bm_hit);
endmodule

// File: rtl/idle_counter.sv
module idle_counter
    import idle_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             reload,
    input  logic             tick,
    input  logic [CNT_W-1:0] start_val,
    output logic [CNT_W-1:0] count,
    output logic             expired
);
    always_ff @(posedge clk) begin
        if (rst) begin
            count   <= START_RST;
            expired <= 1'b0;
        end else begin
            expired <= 1'b0;
            if (reload) begin
                count <= start_val;
            end else if (tick && count != '0) begin
                count <= count - 1'b1;
                if (count == CNT_W'(1)) expired <= 1'b1;
            end
        end
    end

    assert_reload_loads_R9: assert property (@(posedge clk) disable iff (rst)
        reload |=> count == $past(start_val));
    assert_tick_step_R9: assert property (@(posedge clk) disable iff (rst)
        (!reload && tick && count != '0) |=> count == $past(count) - 1'b1);
    assert_expiry_single_R10: assert property (@(posedge clk) disable iff (rst)
        expired |=> !expired);
    assert_expiry_at_zero_R10: assert property (@(posedge clk) disable iff (rst)
        expired |-> count == '0);
    assert_zero_holds_R10: assert property (@(posedge clk) disable iff (rst)
        (count == '0 && !reload) |=> (count == '0 && !expired));
endmodule

// File: rtl/idle_timer_top.sv
module idle_timer_top
    import idle_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [N_TRAP-1:0] trap_stb,
    input  logic              smi_status,
    input  logic              bm_req,
    input  logic [N_IRQ-1:0]  irq_lines,
    input  logic              tick,
    output logic              expired
);
    idle_cfg_t        cfg;
    logic             reload;
    logic [CNT_W-1:0] count;

    idle_regs u_regs (
        .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .count(count), .rdata(reg_rdata), .cfg(cfg)
    );

    idle_activity u_act (
        .clk(clk), .rst(rst), .cfg(cfg), .trap_stb(trap_stb),
        .smi_status(smi_status), .bm_req(bm_req),
        .irq_lines(irq_lines), .reload(reload)
    );

    idle_counter u_cnt (
        .clk(clk), .rst(rst), .reload(reload), .tick(tick),
        .start_val(cfg.start_val), .count(count), .expired(expired)
    );

    assert_smi_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (cfg.smi_en && smi_status) |=> count == $past(cfg.start_val));
endmodule

// File: tb/idle_timer_top_tb.sv
module idle_timer_top_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [12:0] trap_stb = '0;
    logic        smi_status = 1'b0;
    logic        bm_req = 1'b0;
    logic [15:0] irq_lines = '0;
    logic        tick = 1'b0;
    logic        expired;

    int n_run = 0;
    int n_fail = 0;
    int exp_cnt;
    localparam int START = 50;
    localparam logic [31:0] ALL_SRC = 32'h003F_FF80;

    // vector: {enable, trap index}
    localparam int NV = 16;
    localparam logic [4:0] VEC [NV] = '{
        {1'b1,4'd0},{1'b1,4'd1},{1'b1,4'd2},{1'b1,4'd3},{1'b1,4'd4},
        {1'b1,4'd5},{1'b1,4'd6},{1'b1,4'd7},{1'b1,4'd8},{1'b1,4'd9},
        {1'b1,4'd10},{1'b1,4'd11},{1'b1,4'd12},
        {1'b0,4'd3},{1'b0,4'd8},{1'b0,4'd12}};

    always #4 clk = ~clk;

    idle_timer_top u_dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .trap_stb(trap_stb),
        .smi_status(smi_status), .bm_req(bm_req), .irq_lines(irq_lines),
        .tick(tick), .expired(expired)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic do_tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
            if (exp_cnt > 0) exp_cnt--;
        end
    endtask

    task automatic pulse_trap(input int idx);
        @(negedge clk); trap_stb[idx] = 1'b1;
        @(negedge clk); trap_stb = '0;
    endtask

    task automatic chk_cnt(input string req);
        logic [31:0] d;
        rd(2'd3, d);
        check(req, d, 32'(exp_cnt));
    endtask

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rd(2'd0, d); check("R1 src reset", d, 32'h0);
        rd(2'd1, d); check("R1 irq reset", d, 32'h0);
        rd(2'd2, d); check("R1 start reset", d, 32'h0000_FFFF);
        rd(2'd3, d); check("R1 count reset", d, 32'h0000_FFFF);
        // R2 reserved bits
        wr(2'd0, 32'hFFFF_FFFF); rd(2'd0, d); check("R2 src mask", d, ALL_SRC);
        wr(2'd1, 32'hFFFF_FFFF); rd(2'd1, d); check("R2 irq mask", d, 32'h0000_FFFF);
        wr(2'd1, 32'h0);
        wr(2'd2, 32'hABCD_0000 | START); rd(2'd2, d); check("R2 start value", d, START);
        exp_cnt = 32'hFFFF;

        // R3/R4 table walk
        for (int v = 0; v < NV; v++) begin
            logic en;
            int   idx;
            logic [31:0] bit_m;
            en = VEC[v][4];
            idx = int'(VEC[v][3:0]);
            bit_m = 32'h1 << (7 + idx);
            wr(2'd0, en ? bit_m : (ALL_SRC & ~bit_m));
            do_tick(2);
            pulse_trap(idx);
            if (en) exp_cnt = START;
            chk_cnt(en ? "R3 trap reload" : "R4 masked trap");
        end

        // R9 reload wins over tick
        wr(2'd0, ALL_SRC);
        do_tick(3);
        @(negedge clk); tick = 1'b1; trap_stb[0] = 1'b1;
        @(negedge clk); tick = 1'b0; trap_stb = '0;
        exp_cnt = START; chk_cnt("R9 reload priority");
        do_tick(4); chk_cnt("R9 decrement");

        // R5 SMI hold
        wr(2'd0, 32'h1 << 20);
        @(negedge clk); smi_status = 1'b1;
        exp_cnt = START;
        do_tick(5); exp_cnt = START; chk_cnt("R5 smi hold");
        @(negedge clk); smi_status = 1'b0;
        do_tick(2); chk_cnt("R5 smi release");

        // R6 bus master edge
        wr(2'd0, 32'h1 << 21);
        do_tick(2);
        @(negedge clk); bm_req = 1'b1;
        @(negedge clk);
        exp_cnt = START; chk_cnt("R6 bm rising");
        do_tick(3); chk_cnt("R6 bm held no reload");
        @(negedge clk); bm_req = 1'b0;

        // R7 irq INTR line (bit 2), both edges, 3-edge latency
        wr(2'd0, 32'h0);
        wr(2'd1, 32'h0000_0004);
        do_tick(4);
        @(negedge clk); irq_lines[2] = 1'b1;
        @(negedge clk); @(negedge clk);
        chk_cnt("R7 rise not yet");
        @(negedge clk);
        exp_cnt = START; chk_cnt("R7 rise reload");
        do_tick(4);
        @(negedge clk); irq_lines[2] = 1'b0;
        repeat (3) @(negedge clk);
        exp_cnt = START; chk_cnt("R7 fall reload");
        // R8 masked line
        do_tick(4);
        @(negedge clk); irq_lines[5] = 1'b1;
        repeat (4) @(negedge clk);
        chk_cnt("R8 masked irq");
        @(negedge clk); irq_lines[5] = 1'b0;
        repeat (4) @(negedge clk);
        chk_cnt("R8 masked irq fall");

        // R10 expiry
        wr(2'd2, 32'd3);
        wr(2'd0, ALL_SRC);
        pulse_trap(4);
        exp_cnt = 3; chk_cnt("R10 load 3");
        do_tick(2);
        check("R10 no early expiry", {31'b0, expired}, 32'h0);
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0; exp_cnt = 0;
        check("R10 expiry pulse", {31'b0, expired}, 32'h1);
        chk_cnt("R10 zero");
        @(negedge clk);
        check("R10 pulse one cycle", {31'b0, expired}, 32'h0);
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        check("R10 no re-expiry", {31'b0, expired}, 32'h0);
        do_tick(3); chk_cnt("R10 stays zero");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule